// File: doc/BRIEF.md
# Stateful In-Memory Logic Engine

This block holds two small single-bit storage arrays, array A (select code 0) and array B (select code 1). It can work as ordinary bit memory or as a logic engine. In logic mode, a gate step reads two cells of one array and may rewrite one cell of the other array. Every basic function is built from two instructions. A preset step first forces the chosen output cell to a known value with a normal write. The gate step then may flip that cell in one direction only. The result stays in place and can serve as an input to later steps, so chains of steps build larger functions.

An external controller can issue single micro-instructions on the instruction port. It can also start one of two built-in XOR programs. Program 0 is the short one: it uses one OR, one NAND and one AND. Program 1 uses only AND and NAND steps and takes about twice as long. Both programs take their operands from fixed cells of array A (parameters PA1 and PA2), use two scratch cells of array B (PB1 and PB2), and leave the result in cell PA3 of array A.

The controller is a four-state machine. S_IDLE accepts work. S_EXEC runs one single instruction. S_PROG steps through a program, one step per cycle. S_DONE raises the completion pulse. The transitions are:
- S_IDLE to S_PROG on a program start.
- S_IDLE to S_EXEC on a legal instruction.
- S_IDLE stays in S_IDLE on an illegal instruction, which only raises the error flag.
- S_EXEC to S_DONE after one cycle.
- S_PROG to S_DONE after the last step.
- S_DONE to S_IDLE after one cycle.

Top module: `imlogic_engine`

## Requirements
- R1: After reset every cell of both arrays reads 0. In S_IDLE, a memory write (mem_en=1, mem_we=1) stores mem_wdata in the cell given by mem_arr (0 = A, 1 = B) and mem_addr. A memory read (mem_en=1, mem_we=0) presents the cell on mem_rdata one cycle later.
- R2: While busy is high, memory writes are dropped and memory reads return 0 on mem_rdata.
- R3: A preset step (ui_preset=1) writes ui_pval into cell ui_out of array ui_out_arr.
- R4: For a gate step with gate code AND (0) or OR (1), let f be the function of cells ui_in0 and ui_in1 of array ui_in_arr. The output cell becomes its old value AND f, so it can only be cleared. Either array may act as the input side.
- R5: For a gate step with gate code NAND (2) or NOR (3), the output cell becomes its old value OR f, so it can only be set. Either array may act as the input side.
- R6: An instruction is rejected if ui_in_arr equals ui_out_arr, or if it is a preset step whose ui_pval is not 1 for AND or OR and not 0 for NAND or NOR. A rejected instruction raises err for one cycle, leaves every cell unchanged and never raises busy.
- R7: An accepted single instruction holds busy high for exactly two cycles. done is high for exactly one of those cycles, the last one.
- R8: Program 0 (prog_sel=0) leaves A[PA3] = A[PA1] XOR A[PA2], B[PB1] = A[PA1] OR A[PA2] and B[PB2] = A[PA1] NAND A[PA2].
- R9: Program 1 (prog_sel=1) uses only AND and NAND steps and leaves A[PA3] = A[PA1] XOR A[PA2].
- R10: A program holds busy high for its step count plus one: 7 cycles for program 0 and 12 cycles for program 1. done pulses in the last of those cycles. prog_start takes priority over ui_valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_en | input | 1 | Memory-mode access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_arr | input | 1 | Array select, 0 = A, 1 = B |
| mem_addr | input | AW | Cell address |
| mem_wdata | input | 1 | Write data |
| mem_rdata | output | 1 | Read data, one cycle after the request |
| ui_valid | input | 1 | Micro-instruction request |
| ui_preset | input | 1 | 1 = preset step, 0 = gate step |
| ui_gate | input | 2 | Gate code: AND 0, OR 1, NAND 2, NOR 3 |
| ui_in_arr | input | 1 | Array holding the two inputs |
| ui_out_arr | input | 1 | Array holding the output cell |
| ui_in0 | input | AW | First input address |
| ui_in1 | input | AW | Second input address |
| ui_out | input | AW | Output cell address |
| ui_pval | input | 1 | Preset value |
| prog_start | input | 1 | Start a built-in program |
| prog_sel | input | 1 | Program select, 0 = short XOR, 1 = AND/NAND-only XOR |
| busy | output | 1 | Engine is working |
| done | output | 1 | One-cycle pulse at the end of the work |
| err | output | 1 | One-cycle pulse when an instruction is rejected |

## Verification
The assertions check four things on every cycle:
- A gate step never moves its output cell against the gate's allowed direction.
- At most one array is written in any cycle.
- Reads return 0 while the engine is busy.
- done is a single pulse that is always followed by idle, and err only appears while idle.

Only the bench scenarios can show the following:
- The function values of each gate, with both arrays taking the input role.
- That rejected instructions leave the cells intact.
- The exact busy lengths.
- That both XOR programs produce the right result for all four operand pairs.

// File: rtl/imlogic_pkg.sv
package imlogic_pkg;

    typedef enum logic [1:0] {
        G_AND  = 2'd0,
        G_OR   = 2'd1,
        G_NAND = 2'd2,
        G_NOR  = 2'd3
    } gate_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_EXEC,
        S_PROG,
        S_DONE
    } state_e;

    // Control part of one micro-instruction; addresses travel beside it.
    typedef struct packed {
        logic  preset;
        gate_e gate;
        logic  in_arr;
        logic  out_arr;
        logic  pval;
    } ctl_t;

    localparam int STEP_W = 4;

    // Gates that can only clear a preset 1.
    function automatic logic clears_only(gate_e g);
        return (g == G_AND) || (g == G_OR);
    endfunction

    function automatic ctl_t mk_ctl(logic p, gate_e g, logic ia, logic pv);
        ctl_t c;
        c.preset  = p;
        c.gate    = g;
        c.in_arr  = ia;
        c.out_arr = ~ia;
        c.pval    = pv;
        return c;
    endfunction

endpackage

// File: rtl/imlogic_bitarray.sv
module imlogic_bitarray #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic             wdata,
    output logic [DEPTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/imlogic_gate_unit.sv
module imlogic_gate_unit
    import imlogic_pkg::*;
(
    input  ctl_t ctl,
    input  logic in0,
    input  logic in1,
    input  logic old_bit,
    output logic new_bit
);

    logic f;

    always_comb begin
        unique case (ctl.gate)
            G_AND:   f = in0 & in1;
            G_OR:    f = in0 | in1;
            G_NAND:  f = ~(in0 & in1);
            G_NOR:   f = ~(in0 | in1);
            default: f = 1'b0;
        endcase
    end

    always_comb begin
        if (ctl.preset) begin
            new_bit = ctl.pval;
        end else if (clears_only(ctl.gate)) begin
            new_bit = old_bit & f;
        end else begin
            new_bit = old_bit | f;
        end
    end

endmodule

// File: rtl/imlogic_prog_rom.sv
module imlogic_prog_rom
    import imlogic_pkg::*;
#(
    parameter int AW  = 4,
    parameter int PA1 = 0,
    parameter int PA2 = 1,
    parameter int PA3 = 2,
    parameter int PB1 = 0,
    parameter int PB2 = 1
) (
    input  logic              sel,
    input  logic [STEP_W-1:0] step,
    output ctl_t              ctl,
    output logic [AW-1:0]     in0,
    output logic [AW-1:0]     in1,
    output logic [AW-1:0]     out,
    output logic              last
);

    localparam logic [AW-1:0] A1 = AW'(PA1);
    localparam logic [AW-1:0] A2 = AW'(PA2);
    localparam logic [AW-1:0] A3 = AW'(PA3);
    localparam logic [AW-1:0] B1 = AW'(PB1);
    localparam logic [AW-1:0] B2 = AW'(PB2);

    always_comb begin
        ctl  = mk_ctl(1'b1, G_AND, 1'b0, 1'b1);
        in0  = A1;
        in1  = A2;
        out  = B1;
        last = 1'b0;
        if (!sel) begin
            unique case (step)
                4'd0: begin ctl = mk_ctl(1'b1, G_OR,   1'b0, 1'b1); out = B1; end
                4'd1: begin ctl = mk_ctl(1'b0, G_OR,   1'b0, 1'b0); out = B1; end
                4'd2: begin ctl = mk_ctl(1'b1, G_NAND, 1'b0, 1'b0); out = B2; end
                4'd3: begin ctl = mk_ctl(1'b0, G_NAND, 1'b0, 1'b0); out = B2; end
                4'd4: begin ctl = mk_ctl(1'b1, G_AND,  1'b1, 1'b1); out = A3; end
                4'd5: begin
                    ctl = mk_ctl(1'b0, G_AND, 1'b1, 1'b0);
                    in0 = B1; in1 = B2; out = A3; last = 1'b1;
                end
                default: last = 1'b1;
            endcase
        end else begin
            unique case (step)
                4'd0:  begin ctl = mk_ctl(1'b1, G_AND,  1'b0, 1'b1); out = B1; end
                4'd1:  begin ctl = mk_ctl(1'b0, G_AND,  1'b0, 1'b0); out = B1; end
                4'd2:  begin ctl = mk_ctl(1'b1, G_NAND, 1'b1, 1'b0); out = A3; end
                4'd3:  begin ctl = mk_ctl(1'b1, G_AND,  1'b0, 1'b1); out = B2; end
                4'd4:  begin
                    ctl = mk_ctl(1'b0, G_NAND, 1'b1, 1'b0);
                    in0 = B1; in1 = B2; out = A3;
                end
                4'd5:  begin ctl = mk_ctl(1'b1, G_NAND, 1'b0, 1'b0); out = B1; end
                4'd6:  begin
                    ctl = mk_ctl(1'b0, G_NAND, 1'b0, 1'b0);
                    in0 = A1; in1 = A3; out = B1;
                end
                4'd7:  begin ctl = mk_ctl(1'b1, G_NAND, 1'b0, 1'b0); out = B2; end
                4'd8:  begin
                    ctl = mk_ctl(1'b0, G_NAND, 1'b0, 1'b0);
                    in0 = A2; in1 = A3; out = B2;
                end
                4'd9:  begin ctl = mk_ctl(1'b1, G_NAND, 1'b1, 1'b0); out = A3; end
                4'd10: begin
                    ctl = mk_ctl(1'b0, G_NAND, 1'b1, 1'b0);
                    in0 = B1; in1 = B2; out = A3; last = 1'b1;
                end
                default: last = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/imlogic_engine.sv
module imlogic_engine
    import imlogic_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PA1   = 0,
    parameter int PA2   = 1,
    parameter int PA3   = 2,
    parameter int PB1   = 0,
    parameter int PB2   = 1,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mem_en,
    input  logic          mem_we,
    input  logic          mem_arr,
    input  logic [AW-1:0] mem_addr,
    input  logic          mem_wdata,
    output logic          mem_rdata,
    input  logic          ui_valid,
    input  logic          ui_preset,
    input  logic [1:0]    ui_gate,
    input  logic          ui_in_arr,
    input  logic          ui_out_arr,
    input  logic [AW-1:0] ui_in0,
    input  logic [AW-1:0] ui_in1,
    input  logic [AW-1:0] ui_out,
    input  logic          ui_pval,
    input  logic          prog_start,
    input  logic          prog_sel,
    output logic          busy,
    output logic          done,
    output logic          err
);

    state_e state_q, state_d;

    ctl_t              cur_ctl;
    logic [AW-1:0]     cur_in0, cur_in1, cur_out;
    logic              sel_q;
    logic [STEP_W-1:0] step_q;

    ctl_t              rom_ctl, act_ctl;
    logic [AW-1:0]     rom_in0, rom_in1, rom_out;
    logic [AW-1:0]     act_in0, act_in1, act_out;
    logic              rom_last;

    logic              idle, exec, ill, accept_ui;
    logic              in0_bit, in1_bit, old_bit, new_bit;
    logic              gate_step, act_clear_only;
    logic [1:0]        arr_we;
    logic [DEPTH-1:0]  q_arr [2];

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- instruction legality ----------------
    always_comb begin
        ill = (ui_in_arr == ui_out_arr) ||
              (ui_preset && (ui_pval != clears_only(gate_e'(ui_gate))));
    end

    assign accept_ui = ui_valid && !prog_start && !ill;

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (prog_start)     state_d = S_PROG;
                else if (accept_ui) state_d = S_EXEC;
            end
            S_EXEC: state_d = S_DONE;
            S_PROG: if (rom_last) state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // ---------------- outputs of the state machine ----------------
    always_comb begin
        idle = 1'b0;
        exec = 1'b0;
        busy = 1'b1;
        done = 1'b0;
        unique case (state_q)
            S_IDLE: begin idle = 1'b1; busy = 1'b0; end
            S_EXEC: exec = 1'b1;
            S_PROG: exec = 1'b1;
            S_DONE: done = 1'b1;
            default: busy = 1'b1;
        endcase
    end

    // ---------------- captured instruction, step, flags ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ctl   <= '0;
            cur_in0   <= '0;
            cur_in1   <= '0;
            cur_out   <= '0;
            sel_q     <= 1'b0;
            step_q    <= '0;
            err       <= 1'b0;
            mem_rdata <= 1'b0;
        end else begin
            err       <= idle && ui_valid && !prog_start && ill;
            mem_rdata <= (idle && mem_en && !mem_we) ? q_arr[mem_arr][mem_addr] : 1'b0;
            if (idle && prog_start) begin
                sel_q  <= prog_sel;
                step_q <= '0;
            end else if (state_q == S_PROG) begin
                step_q <= step_q + 1'b1;
            end
            if (idle && accept_ui) begin
                cur_ctl.preset  <= ui_preset;
                cur_ctl.gate    <= gate_e'(ui_gate);
                cur_ctl.in_arr  <= ui_in_arr;
                cur_ctl.out_arr <= ui_out_arr;
                cur_ctl.pval    <= ui_pval;
                cur_in0         <= ui_in0;
                cur_in1         <= ui_in1;
                cur_out         <= ui_out;
            end
        end
    end

    // ---------------- program store ----------------
    imlogic_prog_rom #(
        .AW (AW), .PA1(PA1), .PA2(PA2), .PA3(PA3), .PB1(PB1), .PB2(PB2)
    ) u_rom (
        .sel  (sel_q),
        .step (step_q),
        .ctl  (rom_ctl),
        .in0  (rom_in0),
        .in1  (rom_in1),
        .out  (rom_out),
        .last (rom_last)
    );

    // ---------------- active instruction ----------------
    always_comb begin
        if (state_q == S_PROG) begin
            act_ctl = rom_ctl;
            act_in0 = rom_in0;
            act_in1 = rom_in1;
            act_out = rom_out;
        end else begin
            act_ctl = cur_ctl;
            act_in0 = cur_in0;
            act_in1 = cur_in1;
            act_out = cur_out;
        end
    end

    assign in0_bit        = q_arr[act_ctl.in_arr][act_in0];
    assign in1_bit        = q_arr[act_ctl.in_arr][act_in1];
    assign old_bit        = q_arr[act_ctl.out_arr][act_out];
    assign gate_step      = exec && !act_ctl.preset;
    assign act_clear_only = clears_only(act_ctl.gate);

    imlogic_gate_unit u_gate (
        .ctl     (act_ctl),
        .in0     (in0_bit),
        .in1     (in1_bit),
        .old_bit (old_bit),
        .new_bit (new_bit)
    );

    // ---------------- the two arrays ----------------
    for (genvar g = 0; g < 2; g++) begin : g_arr
        logic          we_g;
        logic [AW-1:0] waddr_g;
        logic          wdata_g;

        always_comb begin
            we_g    = (exec && (act_ctl.out_arr == 1'(g))) ||
                      (idle && mem_en && mem_we && (mem_arr == 1'(g)));
            waddr_g = exec ? act_out : mem_addr;
            wdata_g = exec ? new_bit : mem_wdata;
        end

        assign arr_we[g] = we_g;

        imlogic_bitarray #(.DEPTH(DEPTH)) u_bits (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_g),
            .waddr (waddr_g),
            .wdata (wdata_g),
            .q     (q_arr[g])
        );
    end

endmodule

// File: rtl/imlogic_engine_chk.sv
module imlogic_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       mem_rdata,
    input logic [1:0] arr_we,
    input logic       gate_step,
    input logic       act_clear_only,
    input logic       old_bit,
    input logic       new_bit
);

    // R4: AND/OR gate steps may only clear the output cell
    a_r4_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_step && act_clear_only) |-> !(new_bit && !old_bit));

    // R5: NAND/NOR gate steps may only set the output cell
    a_r5_set_only: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_step && !act_clear_only) |-> !(old_bit && !new_bit));

    // R2: reads while busy return 0
    a_r2_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !mem_rdata);

    // R2: one array write per cycle at most
    a_r2_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arr_we));

    // R7: done is a single pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done ends the busy period
    a_r7_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R6: rejection only while idle
    a_r6_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

endmodule

bind imlogic_engine imlogic_engine_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy           (busy),
    .done           (done),
    .err            (err),
    .mem_rdata      (mem_rdata),
    .arr_we         (arr_we),
    .gate_step      (gate_step),
    .act_clear_only (act_clear_only),
    .old_bit        (old_bit),
    .new_bit        (new_bit)
);

// File: tb/imlogic_engine_tb.sv
`timescale 1ns/1ps
module imlogic_engine_tb_top;

    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_en = 1'b0, mem_we = 1'b0, mem_arr = 1'b0, mem_wdata = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic          mem_rdata;
    logic          ui_valid = 1'b0, ui_preset = 1'b0, ui_in_arr = 1'b0, ui_out_arr = 1'b1, ui_pval = 1'b0;
    logic [1:0]    ui_gate = 2'd0;
    logic [AW-1:0] ui_in0 = '0, ui_in1 = '0, ui_out = '0;
    logic          prog_start = 1'b0, prog_sel = 1'b0;
    logic          busy, done, err;

    int n_chk = 0;
    int n_err = 0;
    int last_busy = 0;
    int last_done = 0;
    int last_err  = 0;
    bit finished  = 1'b0;

    always #2 clk = ~clk;

    imlogic_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .mem_en(mem_en), .mem_we(mem_we), .mem_arr(mem_arr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ui_valid(ui_valid), .ui_preset(ui_preset), .ui_gate(ui_gate),
        .ui_in_arr(ui_in_arr), .ui_out_arr(ui_out_arr),
        .ui_in0(ui_in0), .ui_in1(ui_in1), .ui_out(ui_out), .ui_pval(ui_pval),
        .prog_start(prog_start), .prog_sel(prog_sel),
        .busy(busy), .done(done), .err(err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int gate_fn(input int g, input int a, input int b);
        case (g)
            0:       return a & b;
            1:       return a | b;
            2:       return (a & b) ^ 1;
            default: return (a | b) ^ 1;
        endcase
    endfunction

    task automatic mem_write(input int arr, input int addr, input int d);
        @(negedge clk);
        mem_en = 1'b1; mem_we = 1'b1; mem_arr = arr[0]; mem_addr = addr[AW-1:0]; mem_wdata = d[0];
        @(negedge clk);
        mem_en = 1'b0; mem_we = 1'b0;
    endtask

    task automatic mem_read(input int arr, input int addr, output int v);
        @(negedge clk);
        mem_en = 1'b1; mem_we = 1'b0; mem_arr = arr[0]; mem_addr = addr[AW-1:0];
        @(negedge clk);
        v = int'(mem_rdata);
        mem_en = 1'b0;
    endtask

    // Count busy cycles and done pulses until idle again.
    task automatic wait_idle();
        last_busy = 0;
        last_done = 0;
        while (busy) begin
            last_busy++;
            if (done) last_done++;
            @(negedge clk);
        end
    endtask

    task automatic issue(input int pre, input int g, input int ia, input int oa,
                         input int i0, input int i1, input int o, input int pv);
        @(negedge clk);
        ui_valid = 1'b1; ui_preset = pre[0]; ui_gate = g[1:0];
        ui_in_arr = ia[0]; ui_out_arr = oa[0];
        ui_in0 = i0[AW-1:0]; ui_in1 = i1[AW-1:0]; ui_out = o[AW-1:0]; ui_pval = pv[0];
        @(negedge clk);
        ui_valid = 1'b0;
        last_err = int'(err);
        wait_idle();
    endtask

    task automatic run_prog(input int sel);
        @(negedge clk);
        prog_start = 1'b1; prog_sel = sel[0];
        @(negedge clk);
        prog_start = 1'b0;
        wait_idle();
    endtask

    task automatic t_reset();
        int v;
        for (int a = 0; a < 2; a++) begin
            for (int i = 0; i < 16; i += 5) begin
                mem_read(a, i, v);
                chk("R1 reset clear", v, 0);
            end
        end
        chk("R1 busy after reset", int'(busy), 0);
    endtask

    task automatic t_memory();
        int v;
        mem_write(0, 12, 1);
        mem_write(1, 12, 1);
        mem_write(1, 12, 0);
        mem_read(0, 12, v);
        chk("R1 write/read A", v, 1);
        mem_read(1, 12, v);
        chk("R1 overwrite B", v, 0);
    endtask

    task automatic t_single_ops();
        int v, exp, oa;
        for (int g = 0; g < 4; g++) begin
            for (int ia = 0; ia < 2; ia++) begin
                oa = 1 - ia;
                for (int x = 0; x < 4; x++) begin
                    mem_write(ia, 8, x & 1);
                    mem_write(ia, 9, (x >> 1) & 1);
                    issue(1, g, ia, oa, 0, 0, 10, (g < 2) ? 1 : 0);
                    mem_read(oa, 10, v);
                    chk("R3 preset value", v, (g < 2) ? 1 : 0);
                    issue(0, g, ia, oa, 8, 9, 10, 0);
                    exp = gate_fn(g, x & 1, (x >> 1) & 1);
                    mem_read(oa, 10, v);
                    if (g < 2) chk("R4 and/or result", v, exp);
                    else       chk("R5 nand/nor result", v, exp);
                end
            end
        end
    endtask

    task automatic t_one_way();
        int v;
        mem_write(0, 8, 1);
        mem_write(0, 9, 1);
        mem_write(1, 10, 0);
        issue(0, 0, 0, 1, 8, 9, 10, 0);
        mem_read(1, 10, v);
        chk("R4 AND cannot set unpreset 0", v, 0);
        mem_write(1, 10, 1);
        issue(0, 2, 0, 1, 8, 9, 10, 0);
        mem_read(1, 10, v);
        chk("R5 NAND cannot clear unpreset 1", v, 1);
    endtask

    task automatic t_illegal();
        int v;
        mem_write(1, 11, 1);
        issue(1, 0, 0, 1, 0, 0, 11, 0);
        chk("R6 bad preset err", last_err, 1);
        chk("R6 bad preset no busy", last_busy, 0);
        mem_read(1, 11, v);
        chk("R6 bad preset cell kept", v, 1);
        mem_write(0, 11, 0);
        mem_write(0, 8, 0);
        issue(0, 3, 0, 0, 8, 8, 11, 0);
        chk("R6 same array err", last_err, 1);
        mem_read(0, 11, v);
        chk("R6 same array cell kept", v, 0);
    endtask

    task automatic t_timing();
        issue(1, 2, 0, 1, 0, 0, 13, 0);
        chk("R7 single busy cycles", last_busy, 2);
        chk("R7 single done pulses", last_done, 1);
        chk("R7 no err on legal", last_err, 0);
    endtask

    task automatic t_programs();
        int v, a1, a2;
        for (int sel = 0; sel < 2; sel++) begin
            for (int x = 0; x < 4; x++) begin
                a1 = x & 1;
                a2 = (x >> 1) & 1;
                mem_write(0, 0, a1);
                mem_write(0, 1, a2);
                mem_write(0, 2, 1 - (a1 ^ a2));
                run_prog(sel);
                chk(sel == 0 ? "R10 prog0 busy" : "R10 prog1 busy", last_busy, sel == 0 ? 7 : 12);
                chk("R10 prog done pulses", last_done, 1);
                mem_read(0, 2, v);
                if (sel == 0) chk("R8 short XOR", v, a1 ^ a2);
                else          chk("R9 AND/NAND XOR", v, a1 ^ a2);
                if (sel == 0) begin
                    mem_read(1, 0, v);
                    chk("R8 scratch OR", v, a1 | a2);
                    mem_read(1, 1, v);
                    chk("R8 scratch NAND", v, (a1 & a2) ^ 1);
                end
            end
        end
    endtask

    task automatic t_blocked();
        int v;
        mem_write(0, 0, 1);
        mem_write(0, 7, 0);
        @(negedge clk);
        prog_start = 1'b1; prog_sel = 1'b1;
        ui_valid = 1'b1; ui_preset = 1'b1; ui_gate = 2'd0;
        ui_in_arr = 1'b0; ui_out_arr = 1'b1; ui_out = 4'd14; ui_pval = 1'b1;
        @(negedge clk);
        prog_start = 1'b0; ui_valid = 1'b0;
        mem_en = 1'b1; mem_we = 1'b1; mem_arr = 1'b0; mem_addr = 4'd7; mem_wdata = 1'b1;
        @(negedge clk);
        mem_we = 1'b0; mem_addr = 4'd0;
        @(negedge clk);
        chk("R2 read while busy", int'(mem_rdata), 0);
        mem_en = 1'b0;
        wait_idle();
        mem_read(0, 7, v);
        chk("R2 write while busy dropped", v, 0);
        mem_read(1, 14, v);
        chk("R10 prog_start priority", v, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_memory();
        t_single_ops();
        t_one_way();
        t_illegal();
        t_timing();
        t_programs();
        t_blocked();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule